// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the write-only configuration receiver for a two-channel voice coding engine. A host drives a three-wire bus: a serial clock, a data line and an active-low select. Up to 64 such receivers can share that bus, each one strapped to its own 6-bit address. Every transfer starts with an address/command byte. If that byte names this receiver, the bytes that follow load the control register of one channel. They can also load that channel's input and output time-slot numbers.

All inputs are taken as synchronous to the fabric clock `clk`. A rising serial-clock edge is found by comparing the current serial-clock level with its level one cycle earlier. The block also has a strapped mode pin. When that pin is low, the serial receiver is held cleared, and each channel's coding direction, companding law and idle state are taken directly from the address and bus pins. In that mode both time slots read as zero.

While a matched update is in progress, the block raises a strobe that tells the data path to float its channel outputs. A per-channel "done" input lets the engine clear the self-clearing algorithm-reset bit.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, both control outputs read 0x20 (only idle, bit 5, set), all four slot outputs read 0, and `upd_busy` is 0.
- R2: In software mode, `sdi` is captured on each rising `sclk` while `cs_n` is low, least significant bit first. After a matching address byte, the next byte is loaded whole into the selected channel's control register. The other channel is untouched.
- R3: Bit 6 of the address byte selects the channel: 1 selects X, 0 selects Y.
- R4: If address-byte bits 5..0 differ from `dev_addr`, or if bit 7 is 1, the rest of the transfer changes no register.
- R5: In a 4-byte write, byte 3 loads the input slot and byte 4 loads the output slot. Only bits 5..0 are kept, and bits 7..6 are dropped.
- R6: A 2-byte write leaves the time-slot registers of that channel unchanged.
- R7: Raising `cs_n` discards the bit and byte counts. A partly received byte is never stored, and the next transfer starts again with an address byte.
- R8: `sclk` edges while `cs_n` is high change no register.
- R9: Control bit 4 (algorithm reset) is cleared one cycle after the channel's done input is high. The other control bits are kept.
- R10: `upd_busy` rises only after a matching address byte and falls the cycle after `cs_n` goes high. It never rises on a mismatch or in hardware mode.
- R11: With `sw_mode` low, the control outputs are built from pins, and all other control bits read 0 while all slots read 0:
  - X: compress (bit 0) = `dev_addr[0]`, law (bit 2) = `dev_addr[2]`, idle (bit 5) = `cs_n`.
  - Y: compress = `dev_addr[3]`, law = `dev_addr[5]`, idle = `sdi`.
- R12: Hardware mode clears the serial registers. On return to software mode, the reset values of R1 are read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode | input | 1 | 1 = serial configuration, 0 = pin-strapped hardware mode |
| sclk | input | 1 | Serial bus clock level |
| sdi | input | 1 | Serial data; Y idle pin in hardware mode |
| cs_n | input | 1 | Active-low select; X idle pin in hardware mode |
| dev_addr | input | 6 | Strapped device address; coding pins in hardware mode |
| alg_done_x | input | 1 | Channel X algorithm reset finished |
| alg_done_y | input | 1 | Channel Y algorithm reset finished |
| ctl_x | output | 8 | Channel X control register |
| in_slot_x | output | 6 | Channel X input time slot |
| out_slot_x | output | 6 | Channel X output time slot |
| ctl_y | output | 8 | Channel Y control register |
| in_slot_y | output | 6 | Channel Y input time slot |
| out_slot_y | output | 6 | Channel Y output time slot |
| upd_busy | output | 1 | Request to float channel outputs during a matched update |

## Verification
The assertions check four rules on every cycle:
- the busy strobe never rises in hardware mode or while the select is high;
- the strobe drops one cycle after the select rises;
- the slot registers hold still while the bus is deselected;
- the algorithm-reset bit falls only after a done pulse or during a transfer.

Only the directed scenarios can show the parts that depend on data:
- bit order and channel selection;
- rejection of a foreign or reserved address;
- dropping of reserved slot bits;
- discarding of a cut-off byte;
- the pin mapping in hardware mode.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int ADDR_W = 6,
  parameter int SLOT_W = 6,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_mode,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              alg_done_x,
  input  logic              alg_done_y,
  output logic [CTL_W-1:0]  ctl_x,
  output logic [SLOT_W-1:0] in_slot_x,
  output logic [SLOT_W-1:0] out_slot_x,
  output logic [CTL_W-1:0]  ctl_y,
  output logic [SLOT_W-1:0] in_slot_y,
  output logic [SLOT_W-1:0] out_slot_y,
  output logic              upd_busy
);
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(8'h20);
  localparam int IDLE_B = 5;
  localparam int ARST_B = 4;

  logic             sclk_q, hit, sel, busy;
  logic [CTL_W-2:0] shreg;
  logic [2:0]       bitcnt, bytecnt;
  logic [CTL_W-1:0] cx, cy;
  logic [SLOT_W-1:0] isx, osx, isy, osy;

  wire              rise    = sclk & ~sclk_q;
  wire [CTL_W-1:0]  byte_in = {sdi, shreg};
  wire              match   = ~byte_in[7] && byte_in[ADDR_W-1:0] == dev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !sw_mode) begin
      sclk_q <= 1'b0; shreg <= '0; bitcnt <= '0; bytecnt <= '0;
      hit <= 1'b0; sel <= 1'b0; busy <= 1'b0;
      cx <= CTL_RST; cy <= CTL_RST;
      isx <= '0; osx <= '0; isy <= '0; osy <= '0;
    end else begin
      sclk_q <= sclk;
      if (cx[ARST_B] && alg_done_x) cx[ARST_B] <= 1'b0;
      if (cy[ARST_B] && alg_done_y) cy[ARST_B] <= 1'b0;
      if (cs_n) begin
        bitcnt <= '0; bytecnt <= '0; hit <= 1'b0; busy <= 1'b0;
      end else if (rise) begin
        shreg  <= byte_in[CTL_W-1:1];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (bytecnt != 3'd4) bytecnt <= bytecnt + 3'd1;
          case (bytecnt)
            3'd0: begin hit <= match; busy <= match; sel <= byte_in[6]; end
            3'd1: if (hit) begin if (sel) cx <= byte_in; else cy <= byte_in; end
            3'd2: if (hit) begin if (sel) isx <= byte_in[SLOT_W-1:0]; else isy <= byte_in[SLOT_W-1:0]; end
            3'd3: if (hit) begin if (sel) osx <= byte_in[SLOT_W-1:0]; else osy <= byte_in[SLOT_W-1:0]; end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (sw_mode) begin
      ctl_x = cx; ctl_y = cy;
    end else begin
      ctl_x = '0; ctl_x[IDLE_B] = cs_n; ctl_x[2] = dev_addr[2]; ctl_x[0] = dev_addr[0];
      ctl_y = '0; ctl_y[IDLE_B] = sdi;  ctl_y[2] = dev_addr[5]; ctl_y[0] = dev_addr[3];
    end
  end

  assign in_slot_x  = sw_mode ? isx : '0;
  assign out_slot_x = sw_mode ? osx : '0;
  assign in_slot_y  = sw_mode ? isy : '0;
  assign out_slot_y = sw_mode ? osy : '0;
  assign upd_busy   = busy;

  AST_BUSY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_busy) |-> sw_mode && $past(!cs_n)); // R10
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !upd_busy); // R10
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && sw_mode && $past(sw_mode)) |->
      $stable(in_slot_x) && $stable(out_slot_x) && $stable(in_slot_y) && $stable(out_slot_y)); // R8
  AST_ARST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_x[ARST_B]) && sw_mode && $past(sw_mode)) |-> $past(alg_done_x) || !$past(cs_n)); // R9
endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk = 0, rst_n = 0, sw_mode = 1, sclk = 0, sdi = 0, cs_n = 1;
  logic [5:0] dev_addr = 6'h2D;
  logic alg_done_x = 0, alg_done_y = 0;
  logic [7:0] ctl_x, ctl_y;
  logic [5:0] in_slot_x, out_slot_x, in_slot_y, out_slot_y;
  logic upd_busy;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cfg_serial_port u0 (.*);

  localparam logic [7:0] AX = 8'h6D, AY = 8'h2D;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int nb);
    for (int i = 0; i < nb; i++) begin
      sdi = b[i]; sclk = 0; wait_n(2);
      sclk = 1; wait_n(2);
    end
    sclk = 0;
  endtask

  task automatic start(); cs_n = 0; wait_n(2); endtask
  task automatic stop();  sclk = 0; wait_n(2); cs_n = 1; wait_n(3); endtask

  task automatic write2(logic [7:0] a, logic [7:0] c);
    start(); send_bits(a, 8); send_bits(c, 8); stop();
  endtask

  task automatic write4(logic [7:0] a, logic [7:0] c, logic [7:0] i, logic [7:0] o);
    start(); send_bits(a, 8); send_bits(c, 8); send_bits(i, 8); send_bits(o, 8); stop();
  endtask

  task automatic t_reset();
    check("R1 ctl_x", ctl_x, 8'h20);
    check("R1 ctl_y", ctl_y, 8'h20);
    check("R1 slots", {in_slot_x, out_slot_x, in_slot_y, out_slot_y}, 0);
    check("R1 busy", upd_busy, 0);
  endtask

  task automatic t_four_byte();
    write4(AX, 8'h3C, 8'hC5, 8'hEA);
    check("R2 ctl_x", ctl_x, 8'h3C);
    check("R5 in_slot_x", in_slot_x, 6'h05);
    check("R5 out_slot_x", out_slot_x, 6'h2A);
    check("R2 ctl_y untouched", ctl_y, 8'h20);
  endtask

  task automatic t_two_byte();
    write2(AX, 8'hA5);
    check("R2 ctl_x", ctl_x, 8'hA5);
    check("R6 in_slot_x kept", in_slot_x, 6'h05);
    check("R6 out_slot_x kept", out_slot_x, 6'h2A);
  endtask

  task automatic t_chan_y();
    write4(AY, 8'h4B, 8'h3F, 8'h00);
    check("R3 ctl_y", ctl_y, 8'h4B);
    check("R3 in_slot_y", in_slot_y, 6'h3F);
    check("R3 ctl_x untouched", ctl_x, 8'hA5);
  endtask

  task automatic t_mismatch();
    start(); send_bits(8'h6C, 8); wait_n(1);
    check("R10 busy on mismatch", upd_busy, 0);
    send_bits(8'h00, 8); stop();
    check("R4 wrong address", ctl_x, 8'hA5);
    write4(8'hED, 8'h00, 8'h01, 8'h01);
    check("R4 reserved bit set", ctl_x, 8'hA5);
    check("R4 slots kept", in_slot_x, 6'h05);
  endtask

  task automatic t_busy();
    check("R10 idle", upd_busy, 0);
    start(); send_bits(AX, 8); wait_n(1);
    check("R10 busy after match", upd_busy, 1);
    send_bits(8'hA5, 8); stop();
    check("R10 busy dropped", upd_busy, 0);
  endtask

  task automatic t_abort();
    start(); send_bits(AX, 8); send_bits(8'h07, 3); stop();
    check("R7 partial not stored", ctl_x, 8'hA5);
    write2(AX, 8'h81);
    check("R7 fresh transfer", ctl_x, 8'h81);
  endtask

  task automatic t_deselected();
    send_bits(AX, 8); send_bits(8'h00, 8); send_bits(8'h11, 8); send_bits(8'h22, 8);
    wait_n(2);
    check("R8 ctl_x", ctl_x, 8'h81);
    check("R8 in_slot_x", in_slot_x, 6'h05);
  endtask

  task automatic t_alg_reset();
    write2(AX, 8'h95);
    check("R9 set", ctl_x, 8'h95);
    wait_n(4);
    check("R9 held without done", ctl_x, 8'h95);
    alg_done_x = 1; wait_n(1); alg_done_x = 0; wait_n(1);
    check("R9 cleared", ctl_x, 8'h85);
    check("R9 other channel", ctl_y, 8'h4B);
  endtask

  task automatic t_hw_mode();
    sw_mode = 0; dev_addr = 6'b100101; cs_n = 0; sdi = 1; wait_n(3);
    check("R11 ctl_x", ctl_x, 8'h05);
    check("R11 ctl_y", ctl_y, 8'h24);
    check("R11 slots", {in_slot_x, out_slot_x, in_slot_y, out_slot_y}, 0);
    send_bits(AX, 8);
    check("R10 no busy in hw", upd_busy, 0);
    cs_n = 1; sdi = 0; dev_addr = 6'h2D; wait_n(2);
    check("R11 idle x pin", ctl_x[5], 1);
    sw_mode = 1; wait_n(2);
    check("R12 ctl_x cleared", ctl_x, 8'h20);
    check("R12 ctl_y cleared", ctl_y, 8'h20);
    check("R12 in_slot_x cleared", in_slot_x, 0);
  endtask

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset();
    t_four_byte();
    t_two_byte();
    t_chan_y();
    t_mismatch();
    t_busy();
    t_abort();
    t_deselected();
    t_alg_reset();
    t_hw_mode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule